// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Half-Word Masked Writes

This block drives and samples a set of general purpose pins split into `NB` banks of `W` bits each (four banks of 32 bits by default). Each bank holds its own output value, pin direction, output enable and interrupt setup. Software reaches all of it through one 32-bit register port with a valid/ready request and a registered response one cycle later.

Output bits can be changed one half-bank at a time without a read-modify-write. A masked-write word carries a keep-mask in its upper 16 bits and new values in its lower 16. Every pin can raise an interrupt on a level (high or low) or on an edge (rising, falling or both). Status bits latch, are cleared by writing ones, and feed a single interrupt line through a per-pin enable. A summary register shows which banks currently have an enabled pending interrupt, so a handler can go straight to the right bank.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every bank reads 0 in output value (word 0), direction (word 4), output enable (word 5), interrupt enable (word 6), status (word 9), edge select (word 10) and both-edge select (word 12). Polarity (word 11) reads all ones. `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to word 0 of a bank loads all of that bank's output bits, and they appear on `pin_out`. `pin_out` changes only in a cycle after a write was accepted.
- R3: A write to word 1 affects output bits [W/2-1:0] only. For each i, data bit i is loaded when mask bit 16+i is 0 and is kept when that mask bit is 1.
- R4: A write to word 2 does the same for output bits [W-1:W/2], taking data from bits [W/2-1:0] and mask from bits [16+W/2-1:16].
- R5: Each pin's `pin_oe` bit is 1 exactly when both its direction bit (1 = output) and its output-enable bit are 1.
- R6: Word 3 returns the pin inputs after two synchronising flops, whatever the direction setting. Writes to word 3 change neither the outputs nor the read value.
- R7: With edge select 1 and polarity 1, a rising input sets the pin's status bit. The bit stays set until a 1 is written to it in word 9, and it does not return while the input stays high.
- R8: With edge select 1 and polarity 0, only a falling input sets status. With both-edge select 1, either transition sets status, whatever the polarity.
- R9: With edge select 0, status is set while the input matches the polarity (1 = high, 0 = low). If it is cleared while the level is still present, it sets again.
- R10: Writing ones to word 7 sets interrupt-enable bits and writing ones to word 8 clears them. The enable value reads back from word 6.
- R11: `irq` is 1 when any bank has a pin whose status and enable are both 1. Word 15 of any bank returns that per-bank pending flag in bit b for bank b.
- R12: A write addressed to one bank leaves every other bank's outputs and settings unchanged. The byte address is {bank, word, 2'b00}.
- R13: Each accepted request gets `rsp_valid` in the next cycle. For a read, `rsp_rdata` holds the addressed value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (high outside reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address {bank, word, 2'b00} |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| pins_in | input | NB*W | Pin input levels, bank b at [b*W +: W] |
| pin_out | output | NB*W | Pin output values |
| pin_oe | output | NB*W | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The masked writes are swept over every mask and data pattern of a half-bank in a small configuration. A design that inverts the mask sense, or lets one half leak into the other, fails that sweep. The output-enable product is swept over all direction values. Each interrupt mode is driven through both transitions, which shows whether a design swaps polarity, ignores the both-edge override, or lets an edge bit return while the input stays high. The level mode is cleared while its level is held, to confirm that the bit sets again. Enable set and clear, the per-bank summary, and writes to one bank that must not reach another are checked against the `irq` pin and bus reads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_BITS = 4;
  localparam int MASK_LSB = 16;

  typedef enum logic [REG_BITS-1:0] {
    RG_DOUT  = 4'd0,
    RG_MLO   = 4'd1,
    RG_MHI   = 4'd2,
    RG_DIN   = 4'd3,
    RG_DIR   = 4'd4,
    RG_OE    = 4'd5,
    RG_IEN   = 4'd6,
    RG_ISET  = 4'd7,
    RG_ICLR  = 4'd8,
    RG_ISTAT = 4'd9,
    RG_ITYPE = 4'd10,
    RG_IPOL  = 4'd11,
    RG_IANY  = 4'd12,
    RG_SUMM  = 4'd15
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] any_edge,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, edge_ev, lvl_ev;

  always_comb begin
    rise     = cur & ~prev;
    fall     = ~cur & prev;
    edge_hit = (any_edge & (rise | fall)) |
               (~any_edge & ((pol & rise) | (~pol & fall)));
    lvl_hit  = (pol & cur) | (~pol & ~cur);
    edge_ev  = edge_sel & edge_hit;
    lvl_ev   = ~edge_sel & lvl_hit & ~clr;
  end

  // a new edge beats a clear in the same cycle; a level sets again one cycle after its clear
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | edge_ev | lvl_ev;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [31:0]  wdata,
  input  logic [W-1:0] pins_in,
  output logic [31:0]  rdata,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         pending
);
  localparam int HALF = W / 2;

  logic [W-1:0] dout_q, dir_q, oe_q, en_q, typ_q, pol_q, any_q;
  logic [W-1:0] s_cur, s_prev, stat, clr;

  gpio_in_sync #(.W(W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pins_in (pins_in),
    .sync_q  (s_cur),
    .prev_q  (s_prev)
  );

  assign clr = (wr_en && sel == RG_ISTAT) ? wdata[W-1:0] : '0;

  gpio_irq_cell #(.W(W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .cur      (s_cur),
    .prev     (s_prev),
    .edge_sel (typ_q),
    .pol      (pol_q),
    .any_edge (any_q),
    .clr      (clr),
    .stat_q   (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      oe_q   <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '1;
      any_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_DOUT: dout_q <= wdata[W-1:0];
        RG_MLO: begin
          for (int i = 0; i < HALF; i++)
            if (!wdata[MASK_LSB+i]) dout_q[i] <= wdata[i];
        end
        RG_MHI: begin
          for (int i = 0; i < W - HALF; i++)
            if (!wdata[MASK_LSB+i]) dout_q[HALF+i] <= wdata[i];
        end
        RG_DIR:   dir_q <= wdata[W-1:0];
        RG_OE:    oe_q  <= wdata[W-1:0];
        RG_ISET:  en_q  <= en_q | wdata[W-1:0];
        RG_ICLR:  en_q  <= en_q & ~wdata[W-1:0];
        RG_ITYPE: typ_q <= wdata[W-1:0];
        RG_IPOL:  pol_q <= wdata[W-1:0];
        RG_IANY:  any_q <= wdata[W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RG_DOUT:  rdata = 32'(dout_q);
      RG_DIN:   rdata = 32'(s_cur);
      RG_DIR:   rdata = 32'(dir_q);
      RG_OE:    rdata = 32'(oe_q);
      RG_IEN:   rdata = 32'(en_q);
      RG_ISTAT: rdata = 32'(stat);
      RG_ITYPE: rdata = 32'(typ_q);
      RG_IPOL:  rdata = 32'(pol_q);
      RG_IANY:  rdata = 32'(any_q);
      default:  rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q & oe_q;
  assign pending = |(stat & en_q);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int  NB        = 4,
  parameter int  W         = 32,
  localparam int BANK_BITS = $clog2(NB),
  localparam int ADDR_W    = BANK_BITS + REG_BITS + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NB*W-1:0]   pins_in,
  output logic [NB*W-1:0]   pin_out,
  output logic [NB*W-1:0]   pin_oe,
  output logic              irq
);
  logic                 acc;
  logic [BANK_BITS-1:0] bsel;
  reg_sel_e             rsel;
  logic [31:0]          bank_rd [NB];
  logic [NB-1:0]        pend;
  logic [31:0]          rd_mux;

  assign req_ready = ~rst;
  assign acc       = req_valid & req_ready;
  assign bsel      = req_addr[ADDR_W-1 -: BANK_BITS];
  assign rsel      = reg_sel_e'(req_addr[REG_BITS+1:2]);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic wr_en;
    assign wr_en = acc & req_write & (bsel == BANK_BITS'(g));

    gpio_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .sel     (rsel),
      .wdata   (req_wdata),
      .pins_in (pins_in[g*W +: W]),
      .rdata   (bank_rd[g]),
      .pin_out (pin_out[g*W +: W]),
      .pin_oe  (pin_oe[g*W +: W]),
      .pending (pend[g])
    );
  end

  assign rd_mux = (rsel == RG_SUMM) ? 32'(pend) : bank_rd[bsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) rsp_rdata <= req_write ? 32'd0 : rd_mux;
      irq <= |pend;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NB     = 4,
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [NB*W-1:0]   pin_out,
  input logic [NB*W-1:0]   pin_oe,
  input logic              irq
);
  logic wr_acc;
  assign wr_acc = req_valid && req_ready && req_write;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);  // R13
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);  // R13
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> $stable(pin_out));  // R2
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> $stable(pin_oe));  // R5
  AST_FULL_MASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && req_addr == ADDR_W'(4) && req_wdata[31:16] == 16'hFFFF)
      |=> $stable(pin_out));  // R3
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NB(NB), .W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int W  = 8;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic [NB*W-1:0] pins = '0;
  logic [NB*W-1:0] pin_out, pin_oe;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.NB(NB), .W(W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pins_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [AW-1:0] adr(input int b, input int r);
    return {b[1:0], r[3:0], 2'b00};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input int b, input int r, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = adr(b, r); req_wdata = d;
    @(negedge clk);
    chk("R13 write ack", 32'(rsp_valid), 32'd1);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int b, input int r, output logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = adr(b, r);
    @(negedge clk);
    if (rsp_valid !== 1'b1) chk("R13 read ack", 32'(rsp_valid), 32'd1);
    v = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all_stat();
    for (int b = 0; b < NB; b++) wr(b, 9, 32'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] p, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pin_out", 32'(pin_out), 32'd0);
    chk("R1 pin_oe", 32'(pin_oe), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    for (int b = 0; b < NB; b++) begin
      rd(b, 0, v);  chk("R1 dout", v, 0);
      rd(b, 4, v);  chk("R1 dir", v, 0);
      rd(b, 5, v);  chk("R1 oe", v, 0);
      rd(b, 6, v);  chk("R1 ien", v, 0);
      rd(b, 9, v);  chk("R1 stat", v, 0);
      rd(b, 10, v); chk("R1 type", v, 0);
      rd(b, 11, v); chk("R1 pol", v, 32'hFF);
      rd(b, 12, v); chk("R1 any", v, 0);
    end

    // R2 full write, R12 bank independence
    for (int b = 0; b < NB; b++) wr(b, 0, 32'h11 * (b + 1));
    for (int b = 0; b < NB; b++) begin
      chk("R2 pin_out", 32'(pin_out[b*W +: W]), 32'h11 * (b + 1));
      rd(b, 0, v); chk("R12 dout readback", v, 32'h11 * (b + 1));
    end

    // R3 low-half masked write sweep on bank 1
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 16; d++) begin
        p = 8'(8'hA5 ^ (m * 7 + d));
        wr(1, 0, 32'(p));
        wr(1, 1, {12'd0, 4'(m), 12'd0, 4'(d)});
        e = {p[7:4], (p[3:0] & 4'(m)) | (4'(d) & ~4'(m))};
        chk("R3 masked low", 32'(pin_out[W +: W]), 32'(e));
      end
    end
    // R4 high-half sweep on bank 2
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 16; d++) begin
        p = 8'(8'h3C ^ (m * 5 + d));
        wr(2, 0, 32'(p));
        wr(2, 2, {12'd0, 4'(m), 12'd0, 4'(d)});
        e = {(p[7:4] & 4'(m)) | (4'(d) & ~4'(m)), p[3:0]};
        chk("R4 masked high", 32'(pin_out[2*W +: W]), 32'(e));
      end
    end
    chk("R12 bank0 untouched", 32'(pin_out[0 +: W]), 32'h11);
    chk("R12 bank3 untouched", 32'(pin_out[3*W +: W]), 32'h44);

    // R5 output enable product sweep on bank 3
    wr(3, 5, 32'h5A);
    for (int d = 0; d < 256; d++) begin
      wr(3, 4, 32'(d));
      chk("R5 pin_oe", 32'(pin_oe[3*W +: W]), 32'(d) & 32'h5A);
    end
    chk("R12 bank2 oe untouched", 32'(pin_oe[2*W +: W]), 32'd0);
    wr(3, 4, 0); wr(3, 5, 0);

    // R6 synchronised input readback, any direction
    pins = 32'hC3_96_5A_E1;
    idle(4);
    for (int b = 0; b < NB; b++) begin
      rd(b, 3, v); chk("R6 din input dir", v, 32'(pins[b*W +: W]));
    end
    wr(0, 4, 32'hFF);
    rd(0, 3, v); chk("R6 din output dir", v, 32'hE1);
    p = pin_out[0 +: W];
    wr(0, 3, 32'h00);
    chk("R6 din write ignored out", 32'(pin_out[0 +: W]), 32'(p));
    rd(0, 3, v); chk("R6 din write ignored read", v, 32'hE1);
    wr(0, 4, 0);
    pins = '0;
    idle(4);
    clear_all_stat();
    idle(2);
    for (int b = 0; b < NB; b++) begin
      rd(b, 9, v); chk("R9 level cleared after release", v, 0);
    end

    // R7 rising edge on bank 0 pin 2
    wr(0, 10, 32'hFF);
    pins[2] = 1'b1; idle(5);
    rd(0, 9, v); chk("R7 rise sets", v, 32'h04);
    wr(0, 9, 32'h04); idle(4);
    rd(0, 9, v); chk("R7 w1c sticky clear", v, 0);
    pins[2] = 1'b0; idle(5);
    rd(0, 9, v); chk("R7 fall ignored", v, 0);

    // R8 falling on bank 1 pin 6, any-edge on pin 5
    wr(1, 10, 32'hFF);
    wr(1, 11, 32'hBF);
    wr(1, 12, 32'h20);
    pins[W+6] = 1'b1; idle(5);
    rd(1, 9, v); chk("R8 fall mode ignores rise", v, 0);
    pins[W+6] = 1'b0; idle(5);
    rd(1, 9, v); chk("R8 fall sets", v, 32'h40);
    wr(1, 9, 32'hFF);
    pins[W+5] = 1'b1; idle(5);
    rd(1, 9, v); chk("R8 any rise", v, 32'h20);
    wr(1, 9, 32'hFF);
    pins[W+5] = 1'b0; idle(5);
    rd(1, 9, v); chk("R8 any fall", v, 32'h20);
    wr(1, 9, 32'hFF);

    // R9 level high and low on bank 3
    wr(3, 11, 32'hFE);
    idle(4);
    rd(3, 9, v); chk("R9 level low sets", v, 32'h01);
    pins[3*W+1] = 1'b1; idle(5);
    rd(3, 9, v); chk("R9 level high sets", v, 32'h03);
    wr(3, 9, 32'h03);
    rd(3, 9, v); chk("R9 re-asserts while held", v, 32'h03);
    pins[3*W+1] = 1'b0;
    wr(3, 11, 32'hFF);
    idle(4);
    wr(3, 9, 32'hFF);
    idle(2);
    rd(3, 9, v); chk("R9 no level no status", v, 0);

    // R10 / R11 enables and combined interrupt on bank 2 pin 4
    wr(2, 10, 32'h10);
    wr(2, 7, 32'h10);
    rd(2, 6, v); chk("R10 enable set", v, 32'h10);
    wr(2, 7, 32'h01);
    rd(2, 6, v); chk("R10 enable accumulates", v, 32'h11);
    wr(2, 8, 32'h01);
    rd(2, 6, v); chk("R10 enable clear", v, 32'h10);
    idle(3);
    chk("R11 irq idle", 32'(irq), 0);
    pins[2*W+4] = 1'b1; idle(6);
    chk("R11 irq on pending", 32'(irq), 1);
    rd(0, 15, v); chk("R11 bank summary", v, 32'h4);
    wr(2, 8, 32'h10); idle(2);
    chk("R10 irq masked", 32'(irq), 0);
    rd(2, 9, v); chk("R10 status kept while masked", v, 32'h10);
    wr(2, 7, 32'h10); idle(2);
    chk("R10 irq re-enabled", 32'(irq), 1);
    wr(2, 9, 32'h10); idle(2);
    chk("R11 irq after clear", 32'(irq), 0);
    rd(3, 15, v); chk("R11 summary empty", v, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule